// File: doc/BRIEF.md
# Ternary Maximum/Minimum Selector

This block takes two balanced-ternary vectors of `TRITS` trits and returns either the larger or the smaller of the two. The parameter `MODE_MAX` chooses which one. A multiplexer select is not used. A comparator first produces a single trit verdict, and a small table turns that verdict into a boolean flag. The flag then gates two paths:

- The left operand passes only when the flag is true.
- The right operand passes only when the flag is false.

A per-trit merge joins the two gated vectors. Null is a trit value of its own. A null anywhere in either operand makes the verdict null, so both gates close and the whole output is null.

The result is registered once, so the output appears one clock after the operands. Several instances can be placed side by side, one set to maximum and one to minimum, to sort a pair.

Top module: `tern_maxmin`

## Requirements
- R1: While `rst_n` is low, the registered output `res` is cleared to all-null trits (every 2-bit field 2'b00).
- R2: Each trit is a 2-bit field with these encodings: 2'b00 null, 2'b01 minus, 2'b10 zero, 2'b11 one. Field i occupies bits [2i+1:2i], and field `TRITS-1` is the most significant trit.
- R3: With `MODE_MAX`=1 and both operands free of null, `res` equals the operand of greater balanced-ternary value. The trits are scanned from the most significant down, and the first position that differs decides.
- R4: With `MODE_MAX`=0 and both operands free of null, `res` equals the operand of smaller value, decided in the same way.
- R5: When both operands are free of null and equal, `res` equals the right operand, in either mode.
- R6: When any trit of `lhs` or `rhs` is null, every trit of `res` is null.
- R7: `res` reflects the operands present at the previous rising clock edge and is unchanged between edges.
- R8: At no trit position do the two gated paths both carry a non-null trit. For operands free of null, `res` matches `lhs` or `rhs` in every position, never a mix of the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lhs | input | 2*TRITS | Left operand, packed trits |
| rhs | input | 2*TRITS | Right operand, packed trits |
| res | output | 2*TRITS | Registered maximum or minimum, packed trits |

## Verification
In every evaluation, the left path under nullify-on-true and the right path under nullify-on-false are both computed in the same cycle. Only the shared flag keeps them apart at the merge. The bench sweeps every pair of 3-trit codes, null codes included, through a maximum instance and a minimum instance. This provokes greater, smaller, equal and null verdicts back to back. Each registered result is judged against a value the bench computes from the operands' integer weights. A mixed or doubled result would show up as an output equal to neither operand.

// File: rtl/tmm_pkg.sv
package tmm_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t T_NUL = 2'b00;
  localparam trit_t T_NEG = 2'b01;
  localparam trit_t T_ZER = 2'b10;
  localparam trit_t T_POS = 2'b11;

  // boolean trit: true is one, false is zero, null stays null
  function automatic trit_t to_bool(input logic hit, input trit_t verdict);
    if (verdict == T_NUL) return T_NUL;
    return hit ? T_POS : T_ZER;
  endfunction

  // gate one trit: pass when flag equals the wanted boolean
  function automatic trit_t gate_trit(input trit_t flag, input trit_t want, input trit_t v);
    return (flag == want) ? v : T_NUL;
  endfunction

  // merge two trits: the non-null one wins
  function automatic trit_t join_trit(input trit_t a, input trit_t b);
    return (a != T_NUL) ? a : b;
  endfunction
endpackage

// File: rtl/tmm_compare.sv
module tmm_compare
  import tmm_pkg::*;
#(
  parameter int TRITS = 9
) (
  input  logic [2*TRITS-1:0] lhs,
  input  logic [2*TRITS-1:0] rhs,
  output trit_t              verdict
);
  always_comb begin
    logic  decided;
    logic  seen_null;
    trit_t l_t;
    trit_t r_t;
    verdict   = T_ZER;
    decided   = 1'b0;
    seen_null = 1'b0;
    for (int i = TRITS - 1; i >= 0; i--) begin
      l_t = lhs[2*i +: 2];
      r_t = rhs[2*i +: 2];
      if (l_t == T_NUL || r_t == T_NUL) seen_null = 1'b1;
      // code order equals value order for the non-null codes
      if (!decided && l_t != r_t) begin
        verdict = (l_t > r_t) ? T_POS : T_NEG;
        decided = 1'b1;
      end
    end
    if (seen_null) verdict = T_NUL;
  end
endmodule

// File: rtl/tmm_flag.sv
module tmm_flag
  import tmm_pkg::*;
#(
  parameter bit MODE_MAX = 1'b1
) (
  input  trit_t verdict,
  output trit_t flag
);
  generate
    if (MODE_MAX) begin : g_max
      assign flag = to_bool(verdict == T_POS, verdict);
    end else begin : g_min
      assign flag = to_bool(verdict == T_NEG, verdict);
    end
  endgenerate
endmodule

// File: rtl/tmm_nullify.sv
module tmm_nullify
  import tmm_pkg::*;
#(
  parameter int TRITS   = 9,
  parameter bit ON_TRUE = 1'b1
) (
  input  trit_t              flag,
  input  logic [2*TRITS-1:0] din,
  output logic [2*TRITS-1:0] dout
);
  localparam trit_t WANT = ON_TRUE ? T_POS : T_ZER;

  for (genvar i = 0; i < TRITS; i++) begin : g_trit
    assign dout[2*i +: 2] = gate_trit(flag, WANT, din[2*i +: 2]);
  end
endmodule

// File: rtl/tmm_merge.sv
module tmm_merge
  import tmm_pkg::*;
#(
  parameter int TRITS = 9
) (
  input  logic [2*TRITS-1:0] a,
  input  logic [2*TRITS-1:0] b,
  output logic [2*TRITS-1:0] y,
  output logic               clash
);
  logic [TRITS-1:0] both;

  for (genvar i = 0; i < TRITS; i++) begin : g_trit
    assign y[2*i +: 2] = join_trit(a[2*i +: 2], b[2*i +: 2]);
    assign both[i]     = (a[2*i +: 2] != T_NUL) && (b[2*i +: 2] != T_NUL);
  end

  assign clash = |both;
endmodule

// File: rtl/tern_maxmin.sv
module tern_maxmin
  import tmm_pkg::*;
#(
  parameter int TRITS    = 9,
  parameter bit MODE_MAX = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*TRITS-1:0] lhs,
  input  logic [2*TRITS-1:0] rhs,
  output logic [2*TRITS-1:0] res
);
  localparam int W = 2 * TRITS;

  trit_t        verdict;
  trit_t        flag;
  logic [W-1:0] keep_l;
  logic [W-1:0] keep_r;
  logic [W-1:0] merged;
  logic         clash;

  tmm_compare #(.TRITS(TRITS)) u_cmp (
    .lhs(lhs), .rhs(rhs), .verdict(verdict)
  );

  tmm_flag #(.MODE_MAX(MODE_MAX)) u_flag (
    .verdict(verdict), .flag(flag)
  );

  tmm_nullify #(.TRITS(TRITS), .ON_TRUE(1'b1)) u_gate_l (
    .flag(flag), .din(lhs), .dout(keep_l)
  );

  tmm_nullify #(.TRITS(TRITS), .ON_TRUE(1'b0)) u_gate_r (
    .flag(flag), .din(rhs), .dout(keep_r)
  );

  tmm_merge #(.TRITS(TRITS)) u_merge (
    .a(keep_l), .b(keep_r), .y(merged), .clash(clash)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) res <= '0;
    else        res <= merged;
  end
endmodule

// File: rtl/tern_maxmin_chk.sv
module tern_maxmin_chk
  import tmm_pkg::*;
#(
  parameter int TRITS    = 9,
  parameter bit MODE_MAX = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*TRITS-1:0] lhs,
  input logic [2*TRITS-1:0] rhs,
  input logic [2*TRITS-1:0] res,
  input trit_t              verdict,
  input logic               clash
);
  logic any_null;
  always_comb begin
    any_null = 1'b0;
    for (int i = 0; i < TRITS; i++) begin
      if (lhs[2*i +: 2] == T_NUL || rhs[2*i +: 2] == T_NUL) any_null = 1'b1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> res == '0);

  p_max_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE_MAX && verdict == T_POS) |=> res == $past(lhs));

  p_min_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!MODE_MAX && verdict == T_NEG) |=> res == $past(lhs));

  p_tie_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_null && verdict == T_ZER) |=> res == $past(rhs));

  p_null_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_null |=> res == '0);

  p_no_clash_r8: assert property (@(posedge clk) disable iff (!rst_n) !clash);

  p_whole_operand_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_null |=> (res == $past(lhs) || res == $past(rhs)));
endmodule

bind tern_maxmin tern_maxmin_chk #(.TRITS(TRITS), .MODE_MAX(MODE_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .lhs(lhs), .rhs(rhs), .res(res),
  .verdict(verdict), .clash(clash)
);

// File: tb/sim_tern_maxmin.sv
`timescale 1ns/1ps
module sim_tern_maxmin;
  localparam int N = 3;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] lhs = '0;
  logic [W-1:0] rhs = '0;
  logic [W-1:0] res_max;
  logic [W-1:0] res_min;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tern_maxmin #(.TRITS(N), .MODE_MAX(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .lhs(lhs), .rhs(rhs), .res(res_max)
  );
  tern_maxmin #(.TRITS(N), .MODE_MAX(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .lhs(lhs), .rhs(rhs), .res(res_min)
  );

  // integer weight of a packed vector (codes 1,2,3 mean -1,0,+1)
  function automatic int weight(input logic [W-1:0] v);
    int acc = 0;
    for (int i = N - 1; i >= 0; i--) acc = acc * 3 + (int'(v[2*i +: 2]) - 2);
    return acc;
  endfunction

  function automatic bit has_null(input logic [W-1:0] v);
    for (int i = 0; i < N; i++) if (v[2*i +: 2] == 2'b00) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s lhs=%b rhs=%b actual=%b expected=%b", tag, lhs, rhs, got, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    lhs = 6'b11_01_10;
    rhs = 6'b01_11_11;
    repeat (3) @(posedge clk);
    #1;
    check("R1 max reset", res_max, '0);
    check("R1 min reset", res_min, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 directed: lhs = +1,-1,0 = 6 ; rhs = -1,+1,+1 = -5
    @(posedge clk); #1;
    check("R2 max directed", res_max, 6'b11_01_10);
    check("R2 min directed", res_min, 6'b01_11_11);

    // R7: new operands do not show before the next edge
    @(negedge clk);
    lhs = 6'b10_10_01;
    rhs = 6'b10_10_11;
    #1;
    check("R7 max holds", res_max, 6'b11_01_10);
    @(posedge clk); #1;
    check("R7 max updates", res_max, 6'b10_10_11);

    // exhaustive sweep over all codes, null included
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        logic [W-1:0] emax;
        logic [W-1:0] emin;
        @(negedge clk);
        lhs = a[W-1:0];
        rhs = b[W-1:0];
        @(posedge clk); #1;
        if (has_null(lhs) || has_null(rhs)) begin
          check("R6 max null", res_max, '0);
          check("R6 min null", res_min, '0);
        end else if (weight(lhs) == weight(rhs)) begin
          check("R5 max tie", res_max, rhs);
          check("R5 min tie", res_min, rhs);
        end else begin
          emax = (weight(lhs) > weight(rhs)) ? lhs : rhs;
          emin = (weight(lhs) < weight(rhs)) ? lhs : rhs;
          check("R3 max", res_max, emax);
          check("R4 min", res_min, emin);
          if (res_max !== lhs && res_max !== rhs) check("R8 whole operand", res_max, emax);
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule